// File: doc/BRIEF.md
# Protected-Mode Segment Descriptor Loader

This block carries out the load of a segment register under protected-mode addressing. A load request names one of four segment register slots and supplies a 16-bit selector. The block decodes the selector into a descriptor index, a table choice (global or local) and a requested privilege level. It checks the index against the chosen table's limit and, for a usable selector, fetches the 6-byte descriptor one byte per cycle over a byte-wide memory read port. The fetched base, limit and access rights are then placed in a hidden cache that belongs to the target slot.

Each slot keeps its selector and the decoded descriptor fields. Address translation logic reads these fields later through a read port without going back to memory. An index of zero selects no segment. Such a load performs no memory read and leaves the slot marked invalid, except in the code-segment slot, where it is refused. Faults (an index past the table limit, a descriptor whose present flag is clear, or a null load into the code slot) leave the slot's previous contents in place and raise a one-cycle error pulse. While a fetch is running the block reports busy, and new requests are ignored.

Top module: `seg_desc_loader`

## Requirements
- R1: After reset, every slot reads back invalid (cacheValid 0), and busy, memRdEn and loadErr are all 0.
- R2: A request accepted while idle with a non-zero index (selector bits 15:3) and an index not above the table limit drives memRdEn for exactly six consecutive cycles, beginning the cycle after acceptance. The addresses in those cycles are tableBase + index*8 + 0, 1, 2, 3, 4, 5. The global base is used when selector bit 2 is 0, and the local base when it is 1.
- R3: When the fetched descriptor is present, the target slot is updated in the cycle after the sixth read, and not before. The slot then holds valid = 1, the loaded selector, limit = {byte1, byte0}, base = {byte4, byte3, byte2}, access = byte5, and ring = byte5 bits 6:5.
- R4: busy is high from the cycle after acceptance up to the commit: 7 cycles for a fetch and 1 cycle for a null load. A load request presented while busy is high is ignored.
- R5: A null selector (index 0) loaded into any slot other than the code slot (slot 1) performs no memory read, raises no error, and leaves the slot invalid with the loaded selector recorded.
- R6: A null selector loaded into the code slot (slot 1) raises loadErr for one cycle, in the cycle after the request. It performs no memory read, busy stays low, and the slot keeps its previous contents.
- R7: An index above the chosen table's limit (gdtLimit or ldtLimit, given as the largest legal index) raises loadErr for one cycle, in the cycle after the request. It performs no read, and the slot keeps its previous contents.
- R8: A fetched descriptor with the present flag clear (byte5 bit 7 = 0) raises loadErr for one cycle, in the cycle after the sixth read. The slot keeps its previous contents.
- R9: A load into one slot leaves the contents of every other slot unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| loadValid | input | 1 | Load request strobe |
| loadSlot | input | 2 | Target segment register slot |
| loadSel | input | 16 | Selector to load |
| gdtBase | input | 24 | Global table base address |
| gdtLimit | input | 13 | Largest legal global index |
| ldtBase | input | 24 | Local table base address |
| ldtLimit | input | 13 | Largest legal local index |
| memRdEn | output | 1 | Memory read strobe |
| memAddr | output | 24 | Memory read byte address |
| memRdData | input | 8 | Read data, valid in the same cycle as memAddr |
| busy | output | 1 | Load in progress |
| loadErr | output | 1 | One-cycle fault pulse |
| rdSlot | input | 2 | Slot selected for the cache read port |
| cacheValid | output | 1 | Selected slot holds a usable segment |
| cacheSel | output | 16 | Selected slot's selector |
| cacheBase | output | 24 | Selected slot's segment base |
| cacheLimit | output | 16 | Selected slot's segment limit |
| cacheAccess | output | 8 | Selected slot's access rights byte |
| cacheRing | output | 2 | Selected slot's ring level |

## Verification
The bench targets the boundary between index 0 and index 1, the exact table limit and one past it, and the difference in null handling between the code slot and data slots. A design that compared against the limit off by one would refuse a legal descriptor or fetch an illegal one. A design that skipped the null check would issue a read at the table base, and one that ignored the code-slot rule would quietly invalidate the code segment. The bench also loads a non-present descriptor to catch a cache that is written before the present flag is examined. It sends a request in the middle of a fetch to catch a controller that restarts or switches slots while busy. Byte ordering is checked with descriptors whose bytes are all distinct, so any swapped or shifted lane shows up in the read-back.

// File: rtl/segld_pkg.sv
package segld_pkg;
  localparam int SEL_W      = 16;
  localparam int IDX_W      = 13;
  localparam int BASE_W     = 24;
  localparam int LIM_W      = 16;
  localparam int DESC_BYTES = 6;
  localparam int BYTE_IDX_W = $clog2(DESC_BYTES);

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RD0    = 3'd1,
    ST_RD1    = 3'd2,
    ST_RD2    = 3'd3,
    ST_RD3    = 3'd4,
    ST_RD4    = 3'd5,
    ST_RD5    = 3'd6,
    ST_COMMIT = 3'd7
  } ldState_t;

  typedef struct packed {
    logic                  accept;
    logic                  capture;
    logic [BYTE_IDX_W-1:0] byteIdx;
    logic                  commitLoad;
    logic                  commitNull;
  } ldStrobe_t;

  typedef struct packed {
    logic              valid;
    logic [SEL_W-1:0]  sel;
    logic [BASE_W-1:0] base;
    logic [LIM_W-1:0]  limit;
    logic [7:0]        access;
  } segEntry_t;
endpackage

// File: rtl/segld_ctrl.sv
module segld_ctrl
  import segld_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      loadValid,
  input  logic      selIsNull,
  input  logic      overLimit,
  input  logic      isCodeSlot,
  input  logic      presentBit,
  output ldStrobe_t strobe,
  output logic      busy,
  output logic      memRdEn,
  output logic      loadErr
);
  ldState_t state, stateNext;
  logic     pendNull, pendNullNext;
  logic     errNext;

  always_comb begin
    stateNext    = state;
    pendNullNext = pendNull;
    errNext      = 1'b0;
    strobe       = '0;
    unique case (state)
      ST_IDLE: begin
        if (loadValid) begin
          if ((selIsNull && isCodeSlot) || (!selIsNull && overLimit)) begin
            errNext = 1'b1;
          end else begin
            strobe.accept = 1'b1;
            pendNullNext  = selIsNull;
            stateNext     = selIsNull ? ST_COMMIT : ST_RD0;
          end
        end
      end
      ST_COMMIT: begin
        if (pendNull)        strobe.commitNull = 1'b1;
        else if (presentBit) strobe.commitLoad = 1'b1;
        else                 errNext = 1'b1;
        stateNext = ST_IDLE;
      end
      default: begin
        strobe.capture = 1'b1;
        strobe.byteIdx = BYTE_IDX_W'(3'(state) - 3'd1);
        stateNext      = (state == ST_RD5) ? ST_COMMIT : ldState_t'(3'(state) + 3'd1);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      pendNull <= 1'b0;
      loadErr  <= 1'b0;
    end else begin
      state    <= stateNext;
      pendNull <= pendNullNext;
      loadErr  <= errNext;
    end
  end

  assign busy    = (state != ST_IDLE);
  assign memRdEn = (state != ST_IDLE) && (state != ST_COMMIT);
endmodule

// File: rtl/segld_datapath.sv
module segld_datapath
  import segld_pkg::*;
#(
  parameter int SLOTS     = 4,
  parameter int CODE_SLOT = 1,
  parameter int ADDR_W    = 24,
  localparam int SLOT_W   = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ldStrobe_t         strobe,
  input  logic [SLOT_W-1:0] loadSlot,
  input  logic [SEL_W-1:0]  loadSel,
  input  logic [ADDR_W-1:0] gdtBase,
  input  logic [IDX_W-1:0]  gdtLimit,
  input  logic [ADDR_W-1:0] ldtBase,
  input  logic [IDX_W-1:0]  ldtLimit,
  input  logic [7:0]        memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              selIsNull,
  output logic              overLimit,
  output logic              isCodeSlot,
  output logic              presentBit,
  input  logic [SLOT_W-1:0] rdSlot,
  output segEntry_t         rdEntry
);
  logic [IDX_W-1:0]  selIdx;
  logic              selLocal;
  logic [ADDR_W-1:0] tblBase;
  logic [IDX_W-1:0]  tblLim;

  assign selIdx     = loadSel[SEL_W-1:3];
  assign selLocal   = loadSel[2];
  assign tblBase    = selLocal ? ldtBase : gdtBase;
  assign tblLim     = selLocal ? ldtLimit : gdtLimit;
  assign selIsNull  = (selIdx == '0);
  assign overLimit  = (selIdx > tblLim);
  assign isCodeSlot = (32'(loadSlot) == CODE_SLOT);

  logic [SLOT_W-1:0] pendSlot;
  logic [SEL_W-1:0]  pendSel;
  logic [ADDR_W-1:0] descAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendSlot <= '0;
      pendSel  <= '0;
      descAddr <= '0;
    end else if (strobe.accept) begin
      pendSlot <= loadSlot;
      pendSel  <= loadSel;
      descAddr <= tblBase + ADDR_W'({selIdx, 3'b000});
    end
  end

  assign memAddr = descAddr + ADDR_W'(strobe.byteIdx);

  logic [7:0] descByte [DESC_BYTES];

  for (genvar b = 0; b < DESC_BYTES; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rstN) begin
        descByte[b] <= '0;
      end else if (strobe.capture && (32'(strobe.byteIdx) == b)) begin
        descByte[b] <= memRdData;
      end
    end
  end

  assign presentBit = descByte[5][7];

  segEntry_t fresh;
  always_comb begin
    fresh = '0;
    fresh.sel = pendSel;
    if (strobe.commitLoad) begin
      fresh.valid  = 1'b1;
      fresh.limit  = {descByte[1], descByte[0]};
      fresh.base   = {descByte[4], descByte[3], descByte[2]};
      fresh.access = descByte[5];
    end
  end

  segEntry_t entry [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        entry[s] <= '0;
      end else if ((strobe.commitLoad || strobe.commitNull) && (32'(pendSlot) == s)) begin
        entry[s] <= fresh;
      end
    end
  end

  assign rdEntry = entry[rdSlot];
endmodule

// File: rtl/seg_desc_loader.sv
module seg_desc_loader
  import segld_pkg::*;
#(
  parameter int SLOTS     = 4,
  parameter int CODE_SLOT = 1,
  parameter int ADDR_W    = 24,
  localparam int SLOT_W   = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadValid,
  input  logic [SLOT_W-1:0] loadSlot,
  input  logic [15:0]       loadSel,
  input  logic [ADDR_W-1:0] gdtBase,
  input  logic [12:0]       gdtLimit,
  input  logic [ADDR_W-1:0] ldtBase,
  input  logic [12:0]       ldtLimit,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [7:0]        memRdData,
  output logic              busy,
  output logic              loadErr,
  input  logic [SLOT_W-1:0] rdSlot,
  output logic              cacheValid,
  output logic [15:0]       cacheSel,
  output logic [23:0]       cacheBase,
  output logic [15:0]       cacheLimit,
  output logic [7:0]        cacheAccess,
  output logic [1:0]        cacheRing
);
  ldStrobe_t strobe;
  logic      selIsNull, overLimit, isCodeSlot, presentBit;
  segEntry_t rdEntry;

  segld_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .loadValid  (loadValid),
    .selIsNull  (selIsNull),
    .overLimit  (overLimit),
    .isCodeSlot (isCodeSlot),
    .presentBit (presentBit),
    .strobe     (strobe),
    .busy       (busy),
    .memRdEn    (memRdEn),
    .loadErr    (loadErr)
  );

  segld_datapath #(
    .SLOTS     (SLOTS),
    .CODE_SLOT (CODE_SLOT),
    .ADDR_W    (ADDR_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .loadSlot   (loadSlot),
    .loadSel    (loadSel),
    .gdtBase    (gdtBase),
    .gdtLimit   (gdtLimit),
    .ldtBase    (ldtBase),
    .ldtLimit   (ldtLimit),
    .memRdData  (memRdData),
    .memAddr    (memAddr),
    .selIsNull  (selIsNull),
    .overLimit  (overLimit),
    .isCodeSlot (isCodeSlot),
    .presentBit (presentBit),
    .rdSlot     (rdSlot),
    .rdEntry    (rdEntry)
  );

  assign cacheValid  = rdEntry.valid;
  assign cacheSel    = rdEntry.sel;
  assign cacheBase   = rdEntry.base;
  assign cacheLimit  = rdEntry.limit;
  assign cacheAccess = rdEntry.access;
  assign cacheRing   = rdEntry.access[6:5];
endmodule

// File: rtl/segld_chk.sv
module segld_chk #(
  parameter int ADDR_W = 24,
  parameter int SLOT_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              loadValid,
  input logic              memRdEn,
  input logic [ADDR_W-1:0] memAddr,
  input logic              busy,
  input logic              loadErr,
  input logic [SLOT_W-1:0] rdSlot,
  input logic              cacheValid,
  input logic [23:0]       cacheBase
);
  // R2: reads happen only inside a busy fetch
  a_r2_read_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> busy);

  // R2: consecutive reads step by one byte
  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn && $past(memRdEn)) |-> (memAddr == $past(memAddr) + ADDR_W'(1)));

  // R4: a fetch starts only from a request seen while idle
  a_r4_start_from_idle: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memRdEn) |-> $past(loadValid && !busy));

  // R3: the cache does not change while bytes are being fetched
  a_r3_no_early_update: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn && $stable(rdSlot)) |-> ($stable(cacheBase) && $stable(cacheValid)));

  // R6 R7 R8: a fault pulse always leaves the block idle
  a_r7_err_idle: assert property (@(posedge clk) disable iff (!rstN)
    loadErr |-> !busy);
endmodule

bind seg_desc_loader segld_chk #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .loadValid  (loadValid),
  .memRdEn    (memRdEn),
  .memAddr    (memAddr),
  .busy       (busy),
  .loadErr    (loadErr),
  .rdSlot     (rdSlot),
  .cacheValid (cacheValid),
  .cacheBase  (cacheBase)
);

// File: tb/tb_seg_desc_loader.sv
module tb_seg_desc_loader;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadValid = 1'b0;
  logic [1:0]  loadSlot = '0;
  logic [15:0] loadSel = '0;
  logic [23:0] gdtBase = 24'h000100;
  logic [12:0] gdtLimit = 13'd20;
  logic [23:0] ldtBase = 24'h000800;
  logic [12:0] ldtLimit = 13'd5;
  logic        memRdEn;
  logic [23:0] memAddr;
  logic [7:0]  memRdData;
  logic        busy, loadErr;
  logic [1:0]  rdSlot = '0;
  logic        cacheValid;
  logic [15:0] cacheSel;
  logic [23:0] cacheBase;
  logic [15:0] cacheLimit;
  logic [7:0]  cacheAccess;
  logic [1:0]  cacheRing;

  logic [7:0] memArr [4096];
  assign memRdData = memArr[memAddr[11:0]];

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_desc_loader dut (
    .clk(clk), .rstN(rstN), .loadValid(loadValid), .loadSlot(loadSlot), .loadSel(loadSel),
    .gdtBase(gdtBase), .gdtLimit(gdtLimit), .ldtBase(ldtBase), .ldtLimit(ldtLimit),
    .memRdEn(memRdEn), .memAddr(memAddr), .memRdData(memRdData), .busy(busy),
    .loadErr(loadErr), .rdSlot(rdSlot), .cacheValid(cacheValid), .cacheSel(cacheSel),
    .cacheBase(cacheBase), .cacheLimit(cacheLimit), .cacheAccess(cacheAccess),
    .cacheRing(cacheRing)
  );

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic putDesc(input int addr, input logic [15:0] lim, input logic [23:0] base, input logic [7:0] acc);
    memArr[addr]   = lim[7:0];
    memArr[addr+1] = lim[15:8];
    memArr[addr+2] = base[7:0];
    memArr[addr+3] = base[15:8];
    memArr[addr+4] = base[23:16];
    memArr[addr+5] = acc;
  endtask

  // issue one load, then watch it at negedges until busy falls
  task automatic runLoad(input logic [1:0] slot, input logic [15:0] sel, input logic [23:0] expAddr,
                         output int nReads, output int nBusy, output int nErr, output bit addrOk);
    nReads = 0; nBusy = 0; nErr = 0; addrOk = 1;
    @(negedge clk);
    loadSlot = slot; loadSel = sel; loadValid = 1'b1;
    @(negedge clk);
    loadValid = 1'b0;
    for (int g = 0; g < 20 && busy; g++) begin
      if (memRdEn) begin
        if (memAddr !== expAddr + 24'(nReads)) addrOk = 0;
        nReads++;
      end
      if (loadErr) nErr++;
      nBusy++;
      @(negedge clk);
    end
    if (loadErr) nErr++;
  endtask

  task automatic readSlot(input logic [1:0] s);
    rdSlot = s;
    #1;
  endtask

  task automatic checkEntry(input string req, input logic [1:0] s, input bit v, input logic [15:0] sel,
                            input logic [23:0] base, input logic [15:0] lim, input logic [7:0] acc);
    readSlot(s);
    check(req, "valid", 64'(cacheValid), 64'(v));
    check(req, "sel", 64'(cacheSel), 64'(sel));
    if (v) begin
      check(req, "base", 64'(cacheBase), 64'(base));
      check(req, "limit", 64'(cacheLimit), 64'(lim));
      check(req, "access", 64'(cacheAccess), 64'(acc));
      check(req, "ring", 64'(cacheRing), 64'(acc[6:5]));
    end
  endtask

  task automatic testReset();
    for (int s = 0; s < 4; s++) begin
      readSlot(2'(s));
      check("R1", "slot invalid", 64'(cacheValid), 64'd0);
    end
    check("R1", "busy", 64'(busy), 64'd0);
    check("R1", "memRdEn", 64'(memRdEn), 64'd0);
    check("R1", "loadErr", 64'(loadErr), 64'd0);
  endtask

  task automatic testGlobalLoad();
    int r, b, e; bit ok;
    runLoad(2'd0, 16'h001A, 24'h000118, r, b, e, ok);
    check("R2", "global read count", 64'(r), 64'd6);
    check("R2", "global addresses", 64'(ok), 64'd1);
    check("R4", "busy cycles fetch", 64'(b), 64'd7);
    check("R3", "no error", 64'(e), 64'd0);
    checkEntry("R3", 2'd0, 1'b1, 16'h001A, 24'h123456, 16'hBEEF, 8'hC2);
  endtask

  task automatic testLocalLoad();
    int r, b, e; bit ok;
    runLoad(2'd2, 16'h0025, 24'h000820, r, b, e, ok);
    check("R2", "local read count", 64'(r), 64'd6);
    check("R2", "local addresses", 64'(ok), 64'd1);
    checkEntry("R3", 2'd2, 1'b1, 16'h0025, 24'hABCDEF, 16'h0FFF, 8'hB3);
    checkEntry("R9", 2'd0, 1'b1, 16'h001A, 24'h123456, 16'hBEEF, 8'hC2);
  endtask

  task automatic testNullData();
    int r, b, e; bit ok;
    runLoad(2'd3, 16'h0003, 24'h000100, r, b, e, ok);
    check("R5", "null reads", 64'(r), 64'd0);
    check("R4", "busy cycles null", 64'(b), 64'd1);
    check("R5", "null no error", 64'(e), 64'd0);
    checkEntry("R5", 2'd3, 1'b0, 16'h0003, '0, '0, '0);
  endtask

  task automatic testNullCode();
    int r, b, e; bit ok;
    runLoad(2'd1, 16'h0028, 24'h000128, r, b, e, ok);
    checkEntry("R6", 2'd1, 1'b1, 16'h0028, 24'h00F000, 16'hFFFF, 8'h9A);
    runLoad(2'd1, 16'h0000, 24'h000100, r, b, e, ok);
    check("R6", "code null error", 64'(e), 64'd1);
    check("R6", "code null reads", 64'(r), 64'd0);
    check("R6", "code null busy", 64'(b), 64'd0);
    checkEntry("R6", 2'd1, 1'b1, 16'h0028, 24'h00F000, 16'hFFFF, 8'h9A);
  endtask

  task automatic testLimit();
    int r, b, e; bit ok;
    runLoad(2'd0, 16'h00A8, 24'h000100, r, b, e, ok); // global index 21 > 20
    check("R7", "over global error", 64'(e), 64'd1);
    check("R7", "over global reads", 64'(r), 64'd0);
    checkEntry("R7", 2'd0, 1'b1, 16'h001A, 24'h123456, 16'hBEEF, 8'hC2);
    runLoad(2'd3, 16'h0034, 24'h000800, r, b, e, ok); // local index 6 > 5
    check("R7", "over local error", 64'(e), 64'd1);
    checkEntry("R7", 2'd3, 1'b0, 16'h0003, '0, '0, '0);
    runLoad(2'd3, 16'h00A0, 24'h0001A0, r, b, e, ok); // global index 20 == limit
    check("R7", "at limit no error", 64'(e), 64'd0);
    check("R7", "at limit reads", 64'(r), 64'd6);
    checkEntry("R7", 2'd3, 1'b1, 16'h00A0, 24'h0A0B0C, 16'h1234, 8'hE1);
  endtask

  task automatic testNotPresent();
    int r, b, e; bit ok;
    runLoad(2'd2, 16'h0038, 24'h000138, r, b, e, ok);
    check("R8", "absent reads", 64'(r), 64'd6);
    check("R8", "absent error", 64'(e), 64'd1);
    checkEntry("R8", 2'd2, 1'b1, 16'h0025, 24'hABCDEF, 16'h0FFF, 8'hB3);
  endtask

  task automatic testBusyIgnore();
    int nReads = 0;
    @(negedge clk);
    loadSlot = 2'd0; loadSel = 16'h0018; loadValid = 1'b1;   // global index 3
    @(negedge clk);
    loadValid = 1'b0;
    for (int g = 0; g < 20 && busy; g++) begin
      if (memRdEn) nReads++;
      if (g == 2) begin
        loadSlot = 2'd3; loadSel = 16'h0000; loadValid = 1'b1;
      end else begin
        loadValid = 1'b0;
      end
      @(negedge clk);
    end
    loadValid = 1'b0;
    check("R4", "reads with mid-fetch request", 64'(nReads), 64'd6);
    check("R4", "idle after fetch", 64'(busy), 64'd0);
    checkEntry("R4", 2'd3, 1'b1, 16'h00A0, 24'h0A0B0C, 16'h1234, 8'hE1);
    checkEntry("R4", 2'd0, 1'b1, 16'h0018, 24'h123456, 16'hBEEF, 8'hC2);
  endtask

  initial begin
    for (int a = 0; a < 4096; a++) memArr[a] = 8'(a * 7 + 3);
    putDesc(24'h118, 16'hBEEF, 24'h123456, 8'hC2);
    putDesc(24'h820, 16'h0FFF, 24'hABCDEF, 8'hB3);
    putDesc(24'h128, 16'hFFFF, 24'h00F000, 8'h9A);
    putDesc(24'h1A0, 16'h1234, 24'h0A0B0C, 8'hE1);
    putDesc(24'h138, 16'h5555, 24'h777777, 8'h40);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testGlobalLoad();
    testLocalLoad();
    testNullData();
    testNullCode();
    testLimit();
    testNotPresent();
    testBusyIgnore();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule